// File: doc/BRIEF.md
# Serial Clock-Chip Command Interface

This block models the host-facing side of a small clock chip that a processor drives by bit-banging three bits (select, serial clock and data) in one of its control registers. Each host write to that register arrives as a strobe with the three bit values. The block detects a high-to-low clock transition by comparing the clock bit of the current write with the clock bit of the previous write. On each such transition it shifts one bit into a 16-bit frame. The first eight bits form a command and the last eight bits form a data value. Both are sent most significant bit first.

Commands select one of four targets: a 32-byte battery-backed RAM (read or write), a status byte, a control byte, or a set of time-of-day fields. The time fields come in on a binary input bus and are returned as packed BCD. Read data goes back to the host one bit per clock transition on a serial data-out line, which the host samples after its write. A special command clears two status flags and sends a one-cycle pulse to the host's interrupt logic, so that the matching interrupt-status bit can be cleared.

Top module: `rtc_serial_if`

## Requirements
- R1: A frame has 16 sampled bits. Bits 0–7 shift into the command and bits 8–15 shift into the value, both MSB first. Once 16 bits are taken, further clock transitions in the same frame are ignored.
- R2: A bit is taken only on a write strobe with select = 1, clock = 0, and a clock bit of 1 in the previous write. Writes with no high-to-low clock change, and pin changes without a strobe, have no effect. The previous clock bit resets to 0.
- R3: A write with select = 0 aborts the frame. The phase returns to idle and the command and value clear to zero, so the next frame starts from bit 0.
- R4: For commands 0x00–0x1F, the k-th data-phase transition (k = 0..7) drives bit 7−k of RAM byte (command) onto sdo_o. The new value is visible in the cycle after that write.
- R5: For commands 0x80–0x9F, the value is written to RAM byte (command − 0x80) on the 16th transition only. An aborted frame writes nothing.
- R6: Command 0x30 reads the status byte, which resets to 0x90. Command 0x31 reads the control byte, which is CTRL_INIT (default 0x00).
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day of month, month and year (0–99) as packed BCD, with tens in bits 7:4. Every other code in 0x20–0x2F returns 0x00.
- R8: A completed command 0xB1 whose value has bit 2 set clears status bits 4 and 3 (mask 0x18) and raises int_clr_o for exactly one cycle, the cycle after the completing write. With value bit 2 clear, neither happens.
- R9: sdo_o changes only on data-phase transitions of a read command. At all other times it holds its last value.
- R10: Reset loads RAM byte i from RAM_INIT bits 8i+7:8i and clears sdo_o and int_clr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 1 | Host write to the control register carrying the serial bits |
| sel_i | input | 1 | Chip select bit of that write |
| sclk_i | input | 1 | Serial clock bit of that write |
| sdi_i | input | 1 | Serial data bit of that write |
| sec_i | input | 7 | Seconds, binary |
| min_i | input | 7 | Minutes, binary |
| hour_i | input | 7 | Hours, binary |
| mday_i | input | 7 | Day of month, binary |
| mon_i | input | 7 | Month 1–12, binary |
| year_i | input | 7 | Year within century 0–99, binary |
| sdo_o | output | 1 | Serial read data |
| int_clr_o | output | 1 | One-cycle request to clear host interrupt-status bit 2 |

## Verification
The assertions check, on every cycle, the invariants of the frame state. The phase never passes 16. Frame state does not move without a strobe. A deselect leaves the command and value at zero. The data line stays still unless a strobe with the clock low occurs. The interrupt-clear pulse lasts one cycle and coincides with cleared status flags. Only the bench scenarios show the decoded content: which RAM byte or register comes back, in what bit order, the BCD conversion of each time field, the RAM commit happening only on a complete frame, and aborts or noise writes leaving the next frame intact.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RAM_AW    = 5;
  localparam int RAM_BYTES = 1 << RAM_AW;
  localparam int FRAME_LEN = 16;
  localparam int HALF_LEN  = FRAME_LEN / 2;
  localparam int PHASE_W   = $clog2(FRAME_LEN + 1);
  localparam int TIME_W    = 7;

  localparam logic [7:0] CMD_STATUS  = 8'h30;
  localparam logic [7:0] CMD_CONTROL = 8'h31;
  localparam logic [7:0] CMD_CLRFLG  = 8'hB1;
  localparam logic [7:0] CMD_SEC     = 8'h20;
  localparam logic [7:0] CMD_MIN     = 8'h21;
  localparam logic [7:0] CMD_HOUR    = 8'h22;
  localparam logic [7:0] CMD_MDAY    = 8'h24;
  localparam logic [7:0] CMD_MON     = 8'h25;
  localparam logic [7:0] CMD_YEAR    = 8'h26;
  localparam logic [7:0] STAT_CLR_MASK = 8'h18;
  localparam int         CLR_REQ_BIT   = 2;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_RAM, SRC_STATUS, SRC_CONTROL, SRC_TIME
  } rd_src_e;

  function automatic logic [7:0] bin2bcd(input logic [TIME_W-1:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = 8'(v / 10);
    u = 8'(v % 10);
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [RAM_BYTES*8-1:0] ram_init_default();
    logic [RAM_BYTES*8-1:0] r;
    for (int i = 0; i < RAM_BYTES; i++) r[8*i +: 8] = 8'(i * 29) ^ 8'h4B;
    return r;
  endfunction
endpackage

// File: rtl/rtc_frame_ctrl.sv
module rtc_frame_ctrl
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stb_i,
  input  logic               sel_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               active_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [7:0]         cmd_o,
  output logic [7:0]         value_o,
  output logic               shift_o,
  output logic               commit_o,
  output logic [7:0]         value_nxt_o
);
  logic               sclk_prev_q;
  logic               active_q;
  logic [PHASE_W-1:0] phase_q;
  logic [7:0]         cmd_q;
  logic [7:0]         value_q;
  logic               fall;

  assign fall        = wr_stb_i & sel_i & sclk_prev_q & ~sclk_i;
  // idle maps to phase 0 on the first selected write
  assign phase_o     = active_q ? phase_q : '0;
  assign shift_o     = fall & (phase_o < PHASE_W'(FRAME_LEN));
  assign commit_o    = shift_o & (phase_o == PHASE_W'(FRAME_LEN - 1));
  assign value_nxt_o = {value_q[6:0], sdi_i};
  assign active_o    = active_q;
  assign cmd_o       = cmd_q;
  assign value_o     = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      active_q    <= 1'b0;
      phase_q     <= '0;
      cmd_q       <= '0;
      value_q     <= '0;
    end else if (wr_stb_i) begin
      sclk_prev_q <= sclk_i;
      if (!sel_i) begin
        active_q <= 1'b0;
        phase_q  <= '0;
        cmd_q    <= '0;
        value_q  <= '0;
      end else begin
        active_q <= 1'b1;
        if (shift_o) begin
          phase_q <= phase_o + 1'b1;
          if (phase_o < PHASE_W'(HALF_LEN)) cmd_q <= {cmd_q[6:0], sdi_i};
          else                              value_q <= value_nxt_o;
        end else begin
          phase_q <= phase_o;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter logic [RAM_BYTES*8-1:0] RAM_INIT    = ram_init_default(),
  parameter logic [7:0]             STATUS_INIT = 8'h90,
  parameter logic [7:0]             CTRL_INIT   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        value_i,
  input  logic [RAM_AW-1:0] rd_addr_i,
  output logic [7:0]        ram_byte_o,
  output logic [7:0]        status_o,
  output logic [7:0]        control_o,
  output logic              int_clr_o
);
  logic [7:0] ram_q [RAM_BYTES];
  logic [7:0] status_q;
  logic       int_clr_q;
  logic       ram_wr;
  logic       clr_req;

  assign ram_wr  = commit_i & (cmd_i[7:RAM_AW] == {3'b100, {(5-RAM_AW){1'b0}}});
  assign clr_req = commit_i & (cmd_i == CMD_CLRFLG) & value_i[CLR_REQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= RAM_INIT[8*i +: 8];
    end else if (ram_wr) begin
      ram_q[cmd_i[RAM_AW-1:0]] <= value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= STATUS_INIT;
      int_clr_q <= 1'b0;
    end else begin
      int_clr_q <= clr_req;
      if (clr_req) status_q <= status_q & ~STAT_CLR_MASK;
    end
  end

  assign ram_byte_o = ram_q[rd_addr_i];
  assign status_o   = status_q;
  assign control_o  = CTRL_INIT;
  assign int_clr_o  = int_clr_q;
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_pkg::*;
(
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        ram_byte_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        control_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] mday_i,
  input  logic [TIME_W-1:0] mon_i,
  input  logic [TIME_W-1:0] year_i,
  output logic [7:0]        rd_byte_o,
  output logic              rd_valid_o
);
  rd_src_e    src;
  logic [7:0] time_byte;

  always_comb begin
    if (cmd_i < 8'(RAM_BYTES))            src = SRC_RAM;
    else if (cmd_i == CMD_STATUS)         src = SRC_STATUS;
    else if (cmd_i == CMD_CONTROL)        src = SRC_CONTROL;
    else if (cmd_i[7:4] == CMD_SEC[7:4])  src = SRC_TIME;
    else                                  src = SRC_NONE;
  end

  always_comb begin
    unique case (cmd_i)
      CMD_SEC:  time_byte = bin2bcd(sec_i);
      CMD_MIN:  time_byte = bin2bcd(min_i);
      CMD_HOUR: time_byte = bin2bcd(hour_i);
      CMD_MDAY: time_byte = bin2bcd(mday_i);
      CMD_MON:  time_byte = bin2bcd(mon_i);
      CMD_YEAR: time_byte = bin2bcd(year_i);
      default:  time_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (src)
      SRC_RAM:     rd_byte_o = ram_byte_i;
      SRC_STATUS:  rd_byte_o = status_i;
      SRC_CONTROL: rd_byte_o = control_i;
      SRC_TIME:    rd_byte_o = time_byte;
      default:     rd_byte_o = 8'h00;
    endcase
  end

  assign rd_valid_o = (src != SRC_NONE);
endmodule

// File: rtl/rtc_serial_if.sv
module rtc_serial_if
  import rtc_pkg::*;
#(
  parameter logic [RAM_BYTES*8-1:0] RAM_INIT    = ram_init_default(),
  parameter logic [7:0]             STATUS_INIT = 8'h90,
  parameter logic [7:0]             CTRL_INIT   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] mday_i,
  input  logic [TIME_W-1:0] mon_i,
  input  logic [TIME_W-1:0] year_i,
  output logic              sdo_o,
  output logic              int_clr_o
);
  logic               active;
  logic [PHASE_W-1:0] phase;
  logic [7:0]         cmd;
  logic [7:0]         value;
  logic               shift;
  logic               commit;
  logic [7:0]         value_nxt;
  logic [7:0]         ram_byte;
  logic [7:0]         status;
  logic [7:0]         control;
  logic [7:0]         rd_byte;
  logic               rd_valid;
  logic               sdo_q;

  rtc_frame_ctrl u_frame (
    .clk_i, .rst_ni, .wr_stb_i, .sel_i, .sclk_i, .sdi_i,
    .active_o(active), .phase_o(phase), .cmd_o(cmd), .value_o(value),
    .shift_o(shift), .commit_o(commit), .value_nxt_o(value_nxt)
  );

  rtc_regs #(.RAM_INIT(RAM_INIT), .STATUS_INIT(STATUS_INIT), .CTRL_INIT(CTRL_INIT)) u_regs (
    .clk_i, .rst_ni, .commit_i(commit), .cmd_i(cmd), .value_i(value_nxt),
    .rd_addr_i(cmd[RAM_AW-1:0]), .ram_byte_o(ram_byte), .status_o(status),
    .control_o(control), .int_clr_o(int_clr_o)
  );

  rtc_rd_mux u_mux (
    .cmd_i(cmd), .ram_byte_i(ram_byte), .status_i(status), .control_i(control),
    .sec_i, .min_i, .hour_i, .mday_i, .mon_i, .year_i,
    .rd_byte_o(rd_byte), .rd_valid_o(rd_valid)
  );

  // data phases are 8..15: phase[3] set, low bits pick bit 7-k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              sdo_q <= 1'b0;
    else if (shift && phase[3] && rd_valid)   sdo_q <= rd_byte[~phase[2:0]];
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/rtc_serial_if_chk.sv
module rtc_serial_if_chk
  import rtc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_stb_i,
  input logic               sel_i,
  input logic               sclk_i,
  input logic               active,
  input logic [PHASE_W-1:0] phase,
  input logic [7:0]         cmd,
  input logic [7:0]         value,
  input logic [7:0]         status,
  input logic               sdo_o,
  input logic               int_clr_o
);
  p_phase_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> phase <= PHASE_W'(FRAME_LEN));

  p_no_strobe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(cmd) && $stable(value) && $stable(phase) && $stable(active));

  p_abort_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !sel_i) |=> !active && cmd == 8'h00 && value == 8'h00);

  p_sdo_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && sel_i && !sclk_i) |=> $stable(sdo_o));

  p_clr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> !int_clr_o);

  p_clr_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |-> (status & STAT_CLR_MASK) == 8'h00);
endmodule

bind rtc_serial_if rtc_serial_if_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb_i), .sel_i(sel_i), .sclk_i(sclk_i),
  .active(active), .phase(phase), .cmd(cmd), .value(value), .status(status),
  .sdo_o(sdo_o), .int_clr_o(int_clr_o)
);

// File: tb/rtc_serial_if_tb.sv
`timescale 1ns/1ps
module rtc_serial_if_tb;
  localparam int NB = 32;

  function automatic logic [NB*8-1:0] tb_ram();
    logic [NB*8-1:0] r;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = 8'(i * 43) ^ 8'hC6;
    return r;
  endfunction
  localparam logic [NB*8-1:0] TB_RAM = tb_ram();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, sel = 0, sclk = 0, sdi = 0;
  logic [6:0] sec = 0, mins = 0, hr = 0, mday = 0, mon = 0, yr = 0;
  logic sdo, int_clr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_serial_if #(.RAM_INIT(TB_RAM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(wr), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sec_i(sec), .min_i(mins), .hour_i(hr), .mday_i(mday), .mon_i(mon), .year_i(yr),
    .sdo_o(sdo), .int_clr_o(int_clr)
  );

  function automatic logic [7:0] init_byte(input int i);
    return TB_RAM[8*i +: 8];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostwr(input logic s, input logic c, input logic d);
    @(negedge clk); sel = s; sclk = c; sdi = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic deselect();
    hostwr(1'b0, 1'b0, 1'b0);
  endtask

  // full frame; extra = additional edges after bit 15; noise inserts non-edge writes
  task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int extra,
                      input bit noise, output logic [7:0] rd, output bit clr);
    rd = 8'h00; clr = 0;
    for (int i = 0; i < 16 + extra; i++) begin
      logic b;
      b = (i < 8) ? c[7-i] : (i < 16) ? v[15-i] : 1'b1;
      hostwr(1'b1, 1'b1, b);
      hostwr(1'b1, 1'b0, b);
      if (i >= 8 && i < 16) rd[15-i] = sdo;
      if (int_clr) clr = 1;
      if (noise) begin
        hostwr(1'b1, 1'b0, ~b);
        @(negedge clk); sclk = 1'b1; sdi = ~b;
        @(negedge clk); sclk = 1'b0;
      end
    end
  endtask

  task automatic rd_frame(input logic [7:0] c, output logic [7:0] rd);
    bit clr;
    xfer(c, 8'h00, 0, 0, rd, clr);
    deselect();
  endtask

  task automatic t_reset();
    check("R10 sdo reset", {7'b0, sdo}, 8'h00);
    check("R10 int_clr reset", {7'b0, int_clr}, 8'h00);
  endtask

  task automatic t_ram_read();
    logic [7:0] rd;
    rd_frame(8'h00, rd); check("R4 R10 ram[0]", rd, init_byte(0));
    rd_frame(8'h05, rd); check("R4 ram[5]", rd, init_byte(5));
    rd_frame(8'h1F, rd); check("R4 ram[31]", rd, init_byte(31));
  endtask

  task automatic t_ram_write();
    logic [7:0] rd; bit clr;
    xfer(8'h83, 8'hA5, 0, 0, rd, clr); deselect();
    rd_frame(8'h03, rd); check("R5 write 0x83", rd, 8'hA5);
    xfer(8'h9F, 8'h3C, 0, 0, rd, clr); deselect();
    rd_frame(8'h1F, rd); check("R5 write 0x9F", rd, 8'h3C);
  endtask

  task automatic t_abort();
    logic [7:0] rd;
    for (int i = 0; i < 12; i++) begin
      logic b;
      b = (i < 8) ? 8'h84 >> (7 - i) : 1'b1;
      hostwr(1'b1, 1'b1, b); hostwr(1'b1, 1'b0, b);
    end
    deselect();
    rd_frame(8'h04, rd); check("R5 R3 aborted write", rd, init_byte(4));
    for (int i = 0; i < 4; i++) begin hostwr(1'b1, 1'b1, 1'b1); hostwr(1'b1, 1'b0, 1'b1); end
    deselect();
    rd_frame(8'h02, rd); check("R3 frame after abort", rd, init_byte(2));
  endtask

  task automatic t_noise();
    logic [7:0] rd; bit clr;
    xfer(8'h07, 8'h00, 0, 1, rd, clr); deselect();
    check("R2 read with noise writes", rd, init_byte(7));
    xfer(8'h88, 8'h69, 0, 1, rd, clr); deselect();
    rd_frame(8'h08, rd); check("R2 write with noise writes", rd, 8'h69);
  endtask

  task automatic t_extra();
    logic [7:0] rd; bit clr;
    xfer(8'h00, 8'h00, 3, 0, rd, clr);
    check("R1 read with extra edges", rd, init_byte(0));
    check("R1 sdo after extra edges", {7'b0, sdo}, {7'b0, init_byte(0)[0]});
    deselect();
    xfer(8'h86, 8'h11, 2, 0, rd, clr); deselect();
    rd_frame(8'h06, rd); check("R1 write with extra edges", rd, 8'h11);
  endtask

  task automatic t_hold();
    logic [7:0] rd; bit clr; logic last;
    rd_frame(8'h01, rd);
    last = init_byte(1)[0];
    xfer(8'h85, {8{~last}}, 0, 0, rd, clr);
    check("R9 sdo held in write frame", {7'b0, sdo}, {7'b0, last});
    deselect();
    xfer(8'h40, {8{~last}}, 0, 0, rd, clr);
    check("R9 sdo held for unused code", {7'b0, sdo}, {7'b0, last});
    deselect();
  endtask

  task automatic t_status();
    logic [7:0] rd;
    rd_frame(8'h30, rd); check("R6 status reset", rd, 8'h90);
    rd_frame(8'h31, rd); check("R6 control", rd, 8'h00);
  endtask

  task automatic t_time();
    logic [7:0] rd;
    sec = 7'd59; mins = 7'd7; hr = 7'd23; mday = 7'd31; mon = 7'd12; yr = 7'd99;
    rd_frame(8'h20, rd); check("R7 seconds", rd, 8'h59);
    rd_frame(8'h21, rd); check("R7 minutes", rd, 8'h07);
    rd_frame(8'h22, rd); check("R7 hours", rd, 8'h23);
    rd_frame(8'h24, rd); check("R7 mday", rd, 8'h31);
    rd_frame(8'h25, rd); check("R7 month", rd, 8'h12);
    rd_frame(8'h26, rd); check("R7 year", rd, 8'h99);
    rd_frame(8'h23, rd); check("R7 unused 0x23", rd, 8'h00);
    rd_frame(8'h2F, rd); check("R7 unused 0x2F", rd, 8'h00);
    sec = 7'd0;
    rd_frame(8'h20, rd); check("R7 seconds zero", rd, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] rd; bit clr;
    xfer(8'hB1, 8'hFB, 0, 0, rd, clr);
    check("R8 no pulse without bit 2", {7'b0, clr}, 8'h00);
    deselect();
    rd_frame(8'h30, rd); check("R8 status kept", rd, 8'h90);
    xfer(8'hB1, 8'h04, 0, 0, rd, clr);
    check("R8 pulse seen", {7'b0, clr}, 8'h01);
    @(negedge clk);
    check("R8 pulse one cycle", {7'b0, int_clr}, 8'h00);
    deselect();
    rd_frame(8'h30, rd); check("R8 status cleared", rd, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_read();
    t_status();
    t_ram_write();
    t_abort();
    t_noise();
    t_extra();
    t_hold();
    t_time();
    t_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule